// File: doc/BRIEF.md
# Regroupable Multi-Context Register File

This block is the register storage for a wide issue datapath of eight lanes. Each lane has two read ports and one write port. A small mode register splits the lanes into one group of eight, two groups of four, or four groups of two. Each group acts as a separate register file for its own core, so a narrow core never sees a wide core's state.

The array holds four complete register contexts of 64 words of 32 bits each. The four contexts are shared out among the groups that the current mode creates. A single group of eight lanes can reach all four contexts, a group of four can reach two, and a group of two can reach one. Each group picks its resident context with a small index. A task switch is only a change of that index: nothing is copied, and the next access already uses the other context. Contexts are interleaved over the groups, so the groups always use disjoint storage. Contents therefore survive any change of mode or of context selection.

Within a group, a read of a register that a lane of the same group writes in the same cycle returns the new value. Two lanes of one group that write the same register in one cycle are resolved in favour of the higher lane number, and a clash flag is raised for that group. A mode change is accepted only while every group reports idle, and the new mode applies from the next clock edge.

Top module: `polyrf_top`

## Requirements
- R1: Mode code 0 forms one group of lanes 0-7. Code 1 forms group 0 from lanes 0-3 and group 1 from lanes 4-7. Code 2 forms group g from lanes 2g and 2g+1. Code 3 is reserved and never becomes the active mode.
- R2: Each lane has two read ports (port index 2*lane and 2*lane+1) and one write port. Each register is 32 bits wide, with 64 registers per context. A read combinationally returns the register held in its group's active context, and a write is stored at the clock edge.
- R3: Group g takes its local context index from ctx_sel bits [2g+1:2g]. With G groups, only the low log2(4/G) bits of that field are used and the rest are ignored. The physical context is g + local*G. A change of index applies in the same cycle, and no register contents are copied.
- R4: Register contents are preserved across mode changes and context switches. A value written through one mode is read back through any group and local index that maps to the same physical context.
- R5: Register 0 reads as zero in every context, and writes to it are discarded.
- R6: A read of a register that a lane of the same group writes in the same cycle returns the data being written. Writes by lanes of other groups are never forwarded.
- R7: When two or more lanes of one group write the same nonzero register in one cycle, the highest-numbered lane's data is stored and forwarded, and wr_clash bit g is high in that cycle. Lanes in different groups never clash.
- R8: A mode request is accepted, with mode_ack high in that cycle, only when mode_wr is high, the code is not 3 and all grp_busy bits are zero. The new mode appears on mode_o after the next clock edge, and writes in the accepting cycle still use the old mode.
- R9: After reset the mode is 0, wr_clash is zero, and every register of every context reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 2 | Requested mode code |
| mode_wr | input | 1 | Request a mode change this cycle |
| grp_busy | input | 4 | Per-group busy indication; all must be zero for a mode change |
| mode_o | output | 2 | Active mode code |
| mode_ack | output | 1 | Mode request accepted this cycle |
| ctx_sel | input | 8 | Local context index per group, 2 bits per group |
| rd_addr | input | 96 | Sixteen read addresses, 6 bits each, port p at bits [6p+5:6p] |
| rd_data | output | 512 | Sixteen read results, 32 bits each, port p at bits [32p+31:32p] |
| wr_en | input | 8 | Per-lane write enable |
| wr_addr | input | 48 | Per-lane write address, 6 bits each |
| wr_data | input | 256 | Per-lane write data, 32 bits each |
| wr_clash | output | 4 | Per-group same-register write collision this cycle |

## Verification
On every cycle, assertions check four things. The active mode never holds the reserved code, and it moves only after an idle, explicit request. Register 0 of every context stays zero in storage. Each winning write is found at its physical location one cycle later. A clash flag never rises unless at least two lanes write. The bench scenarios are what show the mapping: that the interleaved context numbering puts the same data under different group and index pairs after a mode change, and that unused index bits are ignored. They also show that forwarding stays within a group, that the highest lane wins a collision, and that a write in the accepting cycle of a mode change lands under the old mode.

// File: rtl/polyrf_pkg.sv
package polyrf_pkg;

  // mode codes: number of groups is 1 << code
  typedef enum logic [1:0] {
    MODE_ONE  = 2'd0,
    MODE_TWO  = 2'd1,
    MODE_FOUR = 2'd2,
    MODE_RSVD = 2'd3
  } rf_mode_e;

  // group that a lane belongs to under a given mode code
  function automatic int unsigned lane_group(input int unsigned lane,
                                             input int unsigned mode,
                                             input int unsigned lane_w);
    return lane >> (lane_w - mode);
  endfunction

  // interleaved physical context: group + local * groups
  function automatic int unsigned phys_ctx(input int unsigned grp,
                                           input int unsigned loc,
                                           input int unsigned mode,
                                           input int unsigned num_ctx);
    int unsigned ngrp;
    int unsigned nloc;
    ngrp = 32'd1 << mode;
    nloc = num_ctx >> mode;
    return grp + (loc & (nloc - 32'd1)) * ngrp;
  endfunction

endpackage

// File: rtl/rf_mode_ctl.sv
module rf_mode_ctl #(
  parameter int GRP_MAX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_req,
  input  logic               mode_wr,
  input  logic [GRP_MAX-1:0] grp_busy,
  output logic [1:0]         mode_q,
  output logic               mode_ack
);
  localparam logic [1:0] MAX_CODE = 2'($clog2(GRP_MAX));

  assign mode_ack = mode_wr && (grp_busy == '0) && (mode_req <= MAX_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n)        mode_q <= 2'd0;
    else if (mode_ack) mode_q <= mode_req;
  end

  // R1: reserved code never active
  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q <= MAX_CODE);

  // R8: mode moves only after an idle, explicit request
  assert_mode_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(mode_wr && (grp_busy == '0)));

  // R8: accepted request becomes active on the next edge
  assert_mode_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ack |=> (mode_q == $past(mode_req)));

endmodule

// File: rtl/rf_lane_map.sv
module rf_lane_map
  import polyrf_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int GRP_MAX = 4,
  parameter int NUM_CTX = 4,
  parameter int GRP_W   = 2,
  parameter int CTX_W   = 2
) (
  input  logic [1:0]               mode,
  input  logic [GRP_MAX*CTX_W-1:0] ctx_sel,
  output logic [GRP_W-1:0]         lane_grp  [LANES],
  output logic [CTX_W-1:0]         lane_pctx [LANES]
);
  localparam int LANE_W = $clog2(LANES);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      int unsigned grp;
      int unsigned loc;
      grp = lane_group(l, 32'(mode), LANE_W);
      loc = 32'(ctx_sel[grp*CTX_W +: CTX_W]);
      lane_grp[l]  = GRP_W'(grp);
      lane_pctx[l] = CTX_W'(phys_ctx(grp, loc, 32'(mode), NUM_CTX));
    end
  end

endmodule

// File: rtl/rf_write_arb.sv
module rf_write_arb #(
  parameter int LANES   = 8,
  parameter int GRP_MAX = 4,
  parameter int GRP_W   = 2,
  parameter int AW      = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GRP_W-1:0]   lane_grp [LANES],
  input  logic [LANES-1:0]   wr_en,
  input  logic [AW-1:0]      wr_addr  [LANES],
  output logic [LANES-1:0]   wr_eff,
  output logic [GRP_MAX-1:0] wr_clash
);

  // a lane's write survives unless a higher lane of its group hits the same register
  always_comb begin
    wr_eff   = '0;
    wr_clash = '0;
    for (int l = 0; l < LANES; l++) begin
      wr_eff[l] = wr_en[l] && (wr_addr[l] != '0);
      for (int m = l + 1; m < LANES; m++) begin
        if (wr_en[l] && wr_en[m] && (wr_addr[l] != '0) &&
            (wr_addr[m] == wr_addr[l]) && (lane_grp[m] == lane_grp[l])) begin
          wr_eff[l] = 1'b0;
          wr_clash[lane_grp[l]] = 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < GRP_MAX; g++) begin : g_chk
    // R7: a clash needs at least two writing lanes
    assert_clash_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clash[g] |-> ($countones(wr_en) >= 2));
  end

endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int LANES       = 8,
  parameter int RD_PER_LANE = 2,
  parameter int NUM_CTX     = 4,
  parameter int NREGS       = 64,
  parameter int DW          = 32,
  parameter int AW          = 6,
  parameter int CTX_W       = 2,
  parameter int GRP_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] lane_grp  [LANES],
  input  logic [CTX_W-1:0] lane_pctx [LANES],
  input  logic [LANES-1:0] wr_eff,
  input  logic [AW-1:0]    wr_addr   [LANES],
  input  logic [DW-1:0]    wr_data   [LANES],
  input  logic [AW-1:0]    rd_addr   [LANES*RD_PER_LANE],
  output logic [DW-1:0]    rd_data   [LANES*RD_PER_LANE]
);
  localparam int IDX_W = CTX_W + AW;
  localparam int DEPTH = NUM_CTX * NREGS;
  localparam int NRD   = LANES * RD_PER_LANE;

  logic [DW-1:0]    mem   [DEPTH];
  logic [IDX_W-1:0] w_idx [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_widx
    assign w_idx[l] = {lane_pctx[l], wr_addr[l]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (wr_eff[l]) mem[w_idx[l]] <= wr_data[l];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    localparam int OWNER = p / RD_PER_LANE;
    always_comb begin
      rd_data[p] = mem[{lane_pctx[OWNER], rd_addr[p]}];
      for (int m = 0; m < LANES; m++)
        if (wr_eff[m] && (lane_grp[m] == lane_grp[OWNER]) && (wr_addr[m] == rd_addr[p]))
          rd_data[p] = wr_data[m];
      if (rd_addr[p] == '0) rd_data[p] = '0;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_wchk
    // R2: a surviving write is found in storage one cycle later
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_eff[l] |=> (mem[$past(w_idx[l])] == $past(wr_data[l])));
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_zchk
    // R5: register 0 of every context stays zero
    assert_reg0_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem[c*NREGS] == '0);
  end

endmodule

// File: rtl/polyrf_top.sv
module polyrf_top #(
  parameter  int LANES       = 8,
  parameter  int RD_PER_LANE = 2,
  parameter  int NUM_CTX     = 4,
  parameter  int NREGS       = 64,
  parameter  int DW          = 32,
  localparam int AW          = $clog2(NREGS),
  localparam int CTX_W       = $clog2(NUM_CTX),
  localparam int GRP_MAX     = NUM_CTX,
  localparam int NRD         = LANES * RD_PER_LANE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_req,
  input  logic                     mode_wr,
  input  logic [GRP_MAX-1:0]       grp_busy,
  output logic [1:0]               mode_o,
  output logic                     mode_ack,
  input  logic [GRP_MAX*CTX_W-1:0] ctx_sel,
  input  logic [NRD*AW-1:0]        rd_addr,
  output logic [NRD*DW-1:0]        rd_data,
  input  logic [LANES-1:0]         wr_en,
  input  logic [LANES*AW-1:0]      wr_addr,
  input  logic [LANES*DW-1:0]      wr_data,
  output logic [GRP_MAX-1:0]       wr_clash
);
  localparam int GRP_W = $clog2(GRP_MAX);

  logic [AW-1:0]    wa   [LANES];
  logic [DW-1:0]    wd   [LANES];
  logic [AW-1:0]    ra   [NRD];
  logic [DW-1:0]    rdd  [NRD];
  logic [GRP_W-1:0] grp  [LANES];
  logic [CTX_W-1:0] pctx [LANES];
  logic [LANES-1:0] eff;

  for (genvar l = 0; l < LANES; l++) begin : g_wun
    assign wa[l] = wr_addr[l*AW +: AW];
    assign wd[l] = wr_data[l*DW +: DW];
  end

  for (genvar p = 0; p < NRD; p++) begin : g_run
    assign ra[p] = rd_addr[p*AW +: AW];
    assign rd_data[p*DW +: DW] = rdd[p];
  end

  rf_mode_ctl #(.GRP_MAX(GRP_MAX)) u_mode (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_wr(mode_wr),
    .grp_busy(grp_busy), .mode_q(mode_o), .mode_ack(mode_ack)
  );

  rf_lane_map #(.LANES(LANES), .GRP_MAX(GRP_MAX), .NUM_CTX(NUM_CTX),
                .GRP_W(GRP_W), .CTX_W(CTX_W)) u_map (
    .mode(mode_o), .ctx_sel(ctx_sel), .lane_grp(grp), .lane_pctx(pctx)
  );

  rf_write_arb #(.LANES(LANES), .GRP_MAX(GRP_MAX), .GRP_W(GRP_W), .AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n), .lane_grp(grp), .wr_en(wr_en), .wr_addr(wa),
    .wr_eff(eff), .wr_clash(wr_clash)
  );

  rf_store #(.LANES(LANES), .RD_PER_LANE(RD_PER_LANE), .NUM_CTX(NUM_CTX),
             .NREGS(NREGS), .DW(DW), .AW(AW), .CTX_W(CTX_W), .GRP_W(GRP_W)) u_store (
    .clk(clk), .rst_n(rst_n), .lane_grp(grp), .lane_pctx(pctx), .wr_eff(eff),
    .wr_addr(wa), .wr_data(wd), .rd_addr(ra), .rd_data(rdd)
  );

endmodule

// File: tb/polyrf_top_tb_top.sv
module polyrf_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]   mode_req;
  logic         mode_wr;
  logic [3:0]   grp_busy;
  logic [1:0]   mode_o;
  logic         mode_ack;
  logic [7:0]   ctx_sel;
  logic [95:0]  rd_addr;
  logic [511:0] rd_data;
  logic [7:0]   wr_en;
  logic [47:0]  wr_addr;
  logic [255:0] wr_data;
  logic [3:0]   wr_clash;

  polyrf_top dut_i (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_wr(mode_wr),
    .grp_busy(grp_busy), .mode_o(mode_o), .mode_ack(mode_ack), .ctx_sel(ctx_sel),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_clash(wr_clash)
  );

  int n_chk = 0;
  int n_bad = 0;

  // vector: [44:43] op (1 write, 2 read), [42:40] lane, [39:38] ctx, [37:32] reg, [31:0] data/expected
  localparam int NVEC = 9;
  localparam logic [44:0] VEC [NVEC] = '{
    {2'd1, 3'd0, 2'd0, 6'd5,  32'hA1A1_0005},
    {2'd1, 3'd3, 2'd1, 6'd5,  32'hB2B2_0005},
    {2'd2, 3'd7, 2'd0, 6'd5,  32'hA1A1_0005},
    {2'd2, 3'd2, 2'd1, 6'd5,  32'hB2B2_0005},
    {2'd1, 3'd1, 2'd3, 6'd63, 32'hC3C3_003F},
    {2'd2, 3'd0, 2'd3, 6'd63, 32'hC3C3_003F},
    {2'd2, 3'd0, 2'd2, 6'd63, 32'h0000_0000},
    {2'd1, 3'd6, 2'd0, 6'd0,  32'hFFFF_FFFF},
    {2'd2, 3'd6, 2'd0, 6'd0,  32'h0000_0000}
  };
  logic [44:0] v;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet();
    wr_en    = '0;
    wr_addr  = '0;
    wr_data  = '0;
    rd_addr  = '0;
    mode_wr  = 1'b0;
    mode_req = 2'd0;
    grp_busy = '0;
  endtask

  task automatic set_wr(input int lane, input logic [5:0] a, input logic [31:0] d);
    wr_en[lane] = 1'b1;
    wr_addr[lane*6 +: 6] = a;
    wr_data[lane*32 +: 32] = d;
  endtask

  task automatic set_rd(input int port, input logic [5:0] a);
    rd_addr[port*6 +: 6] = a;
  endtask

  function automatic logic [31:0] rdv(input int port);
    return rd_data[port*32 +: 32];
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    quiet();
    ctx_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    set_rd(3, 6'd5);
    #1;
    check("R9 mode", 32'(mode_o), 32'd0);
    check("R9 clash", 32'(wr_clash), 32'd0);
    check("R9 read zero", rdv(3), 32'd0);

    // table walk in mode 0, ctx in slot 0 (R2 R3 R5)
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      @(negedge clk);
      quiet();
      ctx_sel = {6'd0, v[39:38]};
      if (v[44:43] == 2'd1) begin
        set_wr(int'(v[42:40]), v[37:32], v[31:0]);
      end else begin
        set_rd(int'(v[42:40]) * 2 + (i & 1), v[37:32]);
        #1;
        check(v[37:32] == 6'd0 ? "R5 table" : "R3 table",
              rdv(int'(v[42:40]) * 2 + (i & 1)), v[31:0]);
      end
    end

    // R6 forwarding inside the group
    @(negedge clk);
    quiet();
    ctx_sel = '0;
    set_wr(2, 6'd10, 32'h1234_5678);
    set_rd(11, 6'd10);
    #1;
    check("R6 forward", rdv(11), 32'h1234_5678);
    check("R7 no clash", 32'(wr_clash), 32'd0);
    @(negedge clk);
    quiet();
    set_rd(0, 6'd10);
    #1;
    check("R2 stored", rdv(0), 32'h1234_5678);

    // R7 same-register collision
    @(negedge clk);
    quiet();
    set_wr(1, 6'd12, 32'h0000_1111);
    set_wr(4, 6'd12, 32'h0000_4444);
    set_rd(6, 6'd12);
    #1;
    check("R7 clash flag", 32'(wr_clash), 32'h1);
    check("R7 forward winner", rdv(6), 32'h0000_4444);
    @(negedge clk);
    quiet();
    set_rd(6, 6'd12);
    #1;
    check("R7 stored winner", rdv(6), 32'h0000_4444);
    check("R7 flag clears", 32'(wr_clash), 32'd0);

    // R8 busy blocks a mode change
    @(negedge clk);
    quiet();
    mode_req = 2'd2; mode_wr = 1'b1; grp_busy = 4'b0010;
    #1;
    check("R8 busy ack", 32'(mode_ack), 32'd0);
    @(negedge clk);
    quiet();
    #1;
    check("R8 busy mode", 32'(mode_o), 32'd0);
    // R8 reserved code rejected
    mode_req = 2'd3; mode_wr = 1'b1;
    #1;
    check("R8 reserved ack", 32'(mode_ack), 32'd0);
    @(negedge clk);
    quiet();
    #1;
    check("R1 reserved mode", 32'(mode_o), 32'd0);
    // R8 accepted; write in same cycle uses old mode (ctx 1 -> physical 1)
    mode_req = 2'd2; mode_wr = 1'b1;
    ctx_sel = 8'b0000_0001;
    set_wr(3, 6'd21, 32'h2121_2121);
    #1;
    check("R8 accept ack", 32'(mode_ack), 32'd1);
    check("R8 not yet", 32'(mode_o), 32'd0);
    @(negedge clk);
    quiet();
    #1;
    check("R8 new mode", 32'(mode_o), 32'd2);

    // mode 2: four groups of two; slot 0 holds 3, upper bits ignored -> physical 0
    ctx_sel = 8'b0000_0011;
    set_rd(0, 6'd5);
    set_rd(4, 6'd5);
    set_rd(12, 6'd63);
    set_rd(8, 6'd63);
    set_rd(5, 6'd21);
    #1;
    check("R3 mask grp0", rdv(0), 32'hA1A1_0005);
    check("R4 grp1 phys1", rdv(4), 32'hB2B2_0005);
    check("R4 grp3 phys3", rdv(12), 32'hC3C3_003F);
    check("R1 grp2 phys2", rdv(8), 32'd0);
    check("R8 old-mode write", rdv(5), 32'h2121_2121);

    // R6/R7 group isolation in mode 2
    @(negedge clk);
    quiet();
    set_wr(0, 6'd20, 32'hD0D0_0000);
    set_wr(3, 6'd20, 32'hD3D3_0000);
    set_rd(2, 6'd20);
    set_rd(4, 6'd20);
    set_rd(8, 6'd20);
    #1;
    check("R6 grp0 fwd", rdv(2), 32'hD0D0_0000);
    check("R6 grp1 fwd", rdv(4), 32'hD3D3_0000);
    check("R6 no cross fwd", rdv(8), 32'd0);
    check("R7 cross group", 32'(wr_clash), 32'd0);
    @(negedge clk);
    quiet();
    set_rd(2, 6'd20);
    set_rd(8, 6'd20);
    #1;
    check("R2 grp0 kept", rdv(2), 32'hD0D0_0000);
    check("R1 grp2 untouched", rdv(8), 32'd0);

    // mode 1: two groups of four
    mode_req = 2'd1; mode_wr = 1'b1;
    @(negedge clk);
    quiet();
    ctx_sel = 8'b0000_1101;  // grp1 slot=3 (masked to 1) -> phys 3, grp0 slot=1 -> phys 2
    set_rd(10, 6'd63);
    set_rd(0, 6'd20);
    #1;
    check("R1 mode1", 32'(mode_o), 32'd1);
    check("R3 grp1 phys3", rdv(10), 32'hC3C3_003F);
    check("R3 grp0 phys2", rdv(0), 32'd0);
    ctx_sel = 8'b0000_0000;  // switch: grp0 -> phys 0, grp1 -> phys 1
    set_rd(14, 6'd21);
    #1;
    check("R3 switch grp0", rdv(0), 32'hD0D0_0000);
    check("R4 grp1 phys1", rdv(14), 32'h2121_2121);

    @(negedge clk);
    finish_run();
  end

endmodule